// File: doc/BRIEF.md
# LR/SC Reservation Monitor with Failure Reason Codes

This block keeps a single load-reserved/store-conditional reservation for one hart. It reports the outcome of every store-conditional as a two-bit reason code, not a plain pass/fail bit. A load-reserved request arms the reservation on one aligned 64-byte line and opens a hold window of `WIN_CYC` cycles. A store-conditional to that line succeeds while the reservation is still live. Three things end the reservation: a local interrupt or trap, a remote write that reaches the line, or expiry of the window. After expiry the block spends `BACKOFF_CYC` cycles in a backoff phase.

The compile-time parameter `STRONG` selects the progress level. In weak mode, remote stores and AMOs snooped on the reserved line take the reservation away. In strong mode, a matching snoop that arrives while the window is open is stalled through `snp_stall`. Remote contention therefore cannot make a store-conditional fail, and every failure in strong mode is reported with the local-event code.

The surrounding core drives the request strobes and addresses and the snoop and trap events. It reads `sc_done`, `sc_code` and `sc_ok` one cycle after the store-conditional.

Top module: `lrsc_monitor`

## Requirements
- R1: `sc_done`, `sc_code` and `sc_ok` are registered. They describe the store-conditional presented in the previous cycle. Code 0 means success, 1 means failure for an unspecified reason (including loss of the line to a remote writer), and 2 means failure caused by a local event. While `sc_done` is low, `sc_code` reads 0.
- R2: A store-conditional to the same 64-byte line as the armed reservation returns 0 while the reservation is live. Address bits [5:0] are ignored when matching.
- R3: `sc_ok` is high only together with `sc_done` and a code of 0. It is never high for two cycles in a row.
- R4: In weak mode a snooped remote write to the reserved line ends the reservation and is never stalled. The next store-conditional returns 1.
- R5: In strong mode a snooped remote write to the reserved line while the window is open raises `snp_stall` in the same cycle. The reservation survives and the next store-conditional returns 0.
- R6: In strong mode no store-conditional ever returns 1. Every failure returns 2.
- R7: A local event clears a live reservation, and the next store-conditional returns 2 in both modes. A local event in the same cycle as a store-conditional also makes it return 2.
- R8: A store-conditional with no live reservation, or to a different line, fails. It returns 1 in weak mode and 2 in strong mode.
- R9: Every store-conditional, whether it passes or fails, clears the reservation and releases the hold. A later snoop to the line is not stalled, and a second store-conditional fails.
- R10: A second load-reserved to the line already reserved acts as a plain load. It does not restart the window.
- R11: The window stays open for exactly `WIN_CYC` cycles after the load-reserved is captured. Then the reservation is dropped and a backoff of `BACKOFF_CYC` cycles follows, during which `snp_stall` stays low. A store-conditional after expiry returns 1 in weak mode and 2 in strong mode.
- R12: A snooped write to a different line is never stalled and does not disturb the reservation.
- R13: After reset `sc_done`, `sc_ok` and `snp_stall` are low and no reservation is live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Load-reserved request strobe |
| sc_req | input | 1 | Store-conditional request strobe |
| req_addr | input | AW | Address of the load-reserved or store-conditional |
| snp_wr_vld | input | 1 | Snooped remote store or AMO is present |
| snp_addr | input | AW | Address of the snooped remote write |
| local_evt | input | 1 | Local interrupt or trap taken this cycle |
| sc_done | output | 1 | Store-conditional result valid |
| sc_code | output | 2 | Result code: 0 pass, 1 unspecified failure, 2 local-event failure |
| sc_ok | output | 1 | One-cycle success strobe |
| snp_stall | output | 1 | Holds off the current snooped write (combinational) |

## Verification
A store-conditional result appears one clock edge after the request is captured. The bench drives each request on a falling edge and reads the result on the next falling edge. `snp_stall` is combinational, so the bench checks it a delta after it drives the snoop, within the same cycle. The window boundary is counted in edges from the capture of the load-reserved. The stall is checked on the last open cycle (edge `WIN_CYC`) and again one edge later, so an off-by-one or a restarted window shows up. A weak and a strong instance share all inputs, so each scenario checks both codes at once.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    SC_PASS       = 2'd0,
    SC_FAIL_ANY   = 2'd1,
    SC_FAIL_LOCAL = 2'd2
  } sc_code_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_OPEN,
    PH_BACK
  } phase_e;

  // Two addresses share a granule when they agree above bit lsb.
  function automatic logic same_granule(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input int unsigned lsb);
    return ((a ^ b) >> lsb) == 64'd0;
  endfunction

  // Failure reason: strong mode and local causes both map to the local code.
  function automatic sc_code_e fail_reason(input logic strong_mode,
                                           input logic local_cause);
    return (strong_mode || local_cause) ? SC_FAIL_LOCAL : SC_FAIL_ANY;
  endfunction

endpackage

// File: rtl/lrsc_phase_timer.sv
module lrsc_phase_timer import lrsc_pkg::*; #(
  parameter int unsigned WIN_CYC     = 64,
  parameter int unsigned BACKOFF_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hard_stop,
  input  logic soft_stop,
  output logic phase_open,
  output logic in_backoff,
  output logic expire
);
  localparam int unsigned CMAX = (WIN_CYC > BACKOFF_CYC) ? WIN_CYC : BACKOFF_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  phase_e        ph;
  logic [CW-1:0] cnt;

  assign phase_open = (ph == PH_OPEN);
  assign in_backoff = (ph == PH_BACK);
  assign expire     = phase_open && (cnt == CW'(1)) && !hard_stop && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (hard_stop) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (start) begin
      ph  <= PH_OPEN;
      cnt <= CW'(WIN_CYC);
    end else if (soft_stop) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_OPEN: begin
          if (cnt == CW'(1)) begin
            ph  <= PH_BACK;
            cnt <= CW'(BACKOFF_CYC);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_BACK: begin
          if (cnt == CW'(1)) begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  AST_OPEN_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_open |-> cnt != '0);  // R11
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] arm_addr,
  input  logic          clr,
  input  logic          mark_local,
  input  logic          forget_local,
  output logic          resv_vld,
  output logic [AW-1:0] resv_addr,
  output logic          lost_local
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_vld  <= 1'b0;
      resv_addr <= '0;
    end else if (arm) begin
      resv_vld  <= 1'b1;
      resv_addr <= arm_addr;
    end else if (clr) begin
      resv_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            lost_local <= 1'b0;
    else if (forget_local) lost_local <= 1'b0;
    else if (mark_local)   lost_local <= 1'b1;
  end
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor import lrsc_pkg::*; #(
  parameter int unsigned AW          = 32,
  parameter int unsigned LINE_LSB    = 6,
  parameter int unsigned WIN_CYC     = 64,
  parameter int unsigned BACKOFF_CYC = 16,
  parameter bit          STRONG      = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_req,
  input  logic          sc_req,
  input  logic [AW-1:0] req_addr,
  input  logic          snp_wr_vld,
  input  logic [AW-1:0] snp_addr,
  input  logic          local_evt,
  output logic          sc_done,
  output logic [1:0]    sc_code,
  output logic          sc_ok,
  output logic          snp_stall
);
  logic          resv_vld, lost_local;
  logic [AW-1:0] resv_addr;
  logic          phase_open, in_backoff, expire;

  // Named internal events, kept visible for the assertions.
  logic req_hit, snp_hit, stall_now, remote_kill;
  logic lr_take, timer_start, sc_pass;
  sc_code_e code_next;

  assign req_hit = resv_vld && same_granule(64'(req_addr), 64'(resv_addr), LINE_LSB);
  assign snp_hit = snp_wr_vld && resv_vld &&
                   same_granule(64'(snp_addr), 64'(resv_addr), LINE_LSB);

  generate
    if (STRONG) begin : g_hold
      assign stall_now = phase_open && snp_hit;
    end else begin : g_nohold
      assign stall_now = 1'b0;
    end
  endgenerate

  assign remote_kill = snp_hit && !stall_now;
  assign lr_take     = lr_req && !sc_req && !local_evt && !req_hit;
  assign timer_start = lr_take && !in_backoff;
  assign sc_pass     = sc_req && req_hit && !local_evt && !remote_kill;
  assign code_next   = !sc_req ? SC_PASS :
                       sc_pass ? SC_PASS :
                       fail_reason(STRONG, local_evt || lost_local);
  assign snp_stall   = stall_now;

  lrsc_resv_reg #(.AW(AW)) u_resv (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (lr_take),
    .arm_addr     (req_addr),
    .clr          (sc_req || local_evt || remote_kill || expire),
    .mark_local   (local_evt && resv_vld),
    .forget_local (sc_req || lr_take),
    .resv_vld     (resv_vld),
    .resv_addr    (resv_addr),
    .lost_local   (lost_local)
  );

  lrsc_phase_timer #(.WIN_CYC(WIN_CYC), .BACKOFF_CYC(BACKOFF_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (timer_start),
    .hard_stop  (sc_req || local_evt),
    .soft_stop  (remote_kill),
    .phase_open (phase_open),
    .in_backoff (in_backoff),
    .expire     (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_done <= 1'b0;
      sc_ok   <= 1'b0;
      sc_code <= 2'd0;
    end else begin
      sc_done <= sc_req;
      sc_ok   <= sc_pass;
      sc_code <= code_next;
    end
  end

  AST_OK_WITH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> (sc_done && sc_code == 2'd0));  // R3
  AST_OK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |=> !sc_ok);  // R3
  AST_STRONG_NO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (STRONG && sc_done) |-> sc_code != 2'd1);  // R6
  AST_LOCAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && local_evt) |=> (sc_done && sc_code == 2'd2));  // R7
  AST_STALL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    snp_stall |-> (phase_open && resv_vld && snp_wr_vld));  // R5
  AST_BACKOFF_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_backoff |-> !snp_stall);  // R11
  AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !resv_vld);  // R9
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_done |-> sc_code == 2'd0);  // R1
endmodule

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 32;
  localparam int WIN = 12;
  localparam int BK  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lr_req = 1'b0, sc_req = 1'b0, snp_wr_vld = 1'b0, local_evt = 1'b0;
  logic [AW-1:0] req_addr = '0, snp_addr = '0;
  logic w_done, w_ok, w_stall, s_done, s_ok, s_stall;
  logic [1:0] w_code, s_code;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_monitor #(.AW(AW), .WIN_CYC(WIN), .BACKOFF_CYC(BK), .STRONG(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .sc_req(sc_req), .req_addr(req_addr),
    .snp_wr_vld(snp_wr_vld), .snp_addr(snp_addr), .local_evt(local_evt),
    .sc_done(w_done), .sc_code(w_code), .sc_ok(w_ok), .snp_stall(w_stall));

  lrsc_monitor #(.AW(AW), .WIN_CYC(WIN), .BACKOFF_CYC(BK), .STRONG(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .lr_req(lr_req), .sc_req(sc_req), .req_addr(req_addr),
    .snp_wr_vld(snp_wr_vld), .snp_addr(snp_addr), .local_evt(local_evt),
    .sc_done(s_done), .sc_code(s_code), .sc_ok(s_ok), .snp_stall(s_stall));

  localparam logic [AW-1:0] LINE_A = 32'h0000_4000;
  localparam logic [AW-1:0] LINE_B = 32'h0000_4040;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_lr(input logic [AW-1:0] a);
    lr_req = 1'b1; req_addr = a;
    step(1);
    lr_req = 1'b0;
  endtask

  // SC: both instances report one edge later; codes expected per mode.
  task automatic do_sc(input logic [AW-1:0] a, input int exp_w, input int exp_s,
                       input string tag);
    sc_req = 1'b1; req_addr = a;
    step(1);
    sc_req = 1'b0; local_evt = 1'b0;
    chk({tag, " weak done"}, w_done, 1);
    chk({tag, " weak code"}, w_code, exp_w);
    chk({tag, " weak ok"}, w_ok, (exp_w == 0) ? 1 : 0);
    chk({tag, " strong done"}, s_done, 1);
    chk({tag, " strong code"}, s_code, exp_s);
    chk({tag, " strong ok"}, s_ok, (exp_s == 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    chk("R13 weak done", w_done, 0);   chk("R13 weak ok", w_ok, 0);
    chk("R13 strong done", s_done, 0); chk("R13 strong ok", s_ok, 0);
    snp_wr_vld = 1'b1; snp_addr = LINE_A; #1;
    chk("R13 no stall", s_stall, 0);
    snp_wr_vld = 1'b0;
    do_sc(LINE_A, 1, 2, "R13 sc without lr");
    step(1);
  endtask

  task automatic t_basic_pass;
    do_lr(LINE_A);
    do_sc(LINE_A | 32'h3c, 0, 0, "R2 same line low bits differ");
    chk("R3 weak ok drops", w_ok, 1); // still the same sample; move on
    step(1);
    chk("R3 weak ok single cycle", w_ok, 0);
    chk("R3 strong ok single cycle", s_ok, 0);
    chk("R1 code idle after result", w_code, 0);
  endtask

  task automatic t_no_resv_and_miss;
    do_sc(LINE_A, 1, 2, "R8 no reservation");
    do_lr(LINE_A);
    do_sc(LINE_B, 1, 2, "R8 other line");
  endtask

  task automatic t_remote_hit;
    do_lr(LINE_A);
    snp_wr_vld = 1'b1; snp_addr = LINE_A + 32'h10; #1;
    chk("R4 weak never stalls", w_stall, 0);
    chk("R5 strong stalls remote hit", s_stall, 1);
    step(1);
    snp_wr_vld = 1'b0;
    do_sc(LINE_A, 1, 0, "R4 R5 sc after remote write");
  endtask

  task automatic t_remote_miss;
    do_lr(LINE_A);
    snp_wr_vld = 1'b1; snp_addr = LINE_B; #1;
    chk("R12 weak other line", w_stall, 0);
    chk("R12 strong other line", s_stall, 0);
    step(1);
    snp_wr_vld = 1'b0;
    do_sc(LINE_A, 0, 0, "R12 reservation kept");
  endtask

  task automatic t_local;
    do_lr(LINE_A);
    local_evt = 1'b1;
    step(1);
    local_evt = 1'b0;
    do_sc(LINE_A, 2, 2, "R7 trap before sc");
    do_lr(LINE_A);
    local_evt = 1'b1;
    do_sc(LINE_A, 2, 2, "R7 trap with sc");
  endtask

  task automatic t_sc_clears;
    do_lr(LINE_A);
    do_sc(LINE_A, 0, 0, "R9 first sc");
    snp_wr_vld = 1'b1; snp_addr = LINE_A; #1;
    chk("R9 hold released", s_stall, 0);
    step(1);
    snp_wr_vld = 1'b0;
    do_sc(LINE_A, 1, 2, "R9 second sc");
  endtask

  task automatic t_expiry;
    do_lr(LINE_A);          // captured on edge 1
    step(WIN);              // now past edge WIN+1: backoff
    snp_wr_vld = 1'b1; snp_addr = LINE_A; #1;
    chk("R11 no stall in backoff", s_stall, 0);
    snp_wr_vld = 1'b0;
    do_sc(LINE_A, 1, 2, "R11 sc after expiry");
    step(BK + 2);
  endtask

  task automatic t_relr_no_restart;
    do_lr(LINE_A);          // edge 1
    step(2);                // past edge 3
    do_lr(LINE_A | 32'h8);  // edge 4, plain load
    step(WIN - 4);          // past edge WIN: last open cycle
    snp_wr_vld = 1'b1; snp_addr = LINE_A; #1;
    chk("R10 R11 still open at edge WIN", s_stall, 1);
    step(1);                // past edge WIN+1
    #1;
    chk("R10 window not restarted", s_stall, 0);
    snp_wr_vld = 1'b0;
    sc_req = 1'b1; req_addr = LINE_A;
    step(1);
    sc_req = 1'b0;
    chk("R11 strong expired code", s_code, 2);
    chk("R6 strong never one", (s_code == 2'd1) ? 1 : 0, 0);
    step(BK + 2);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_basic_pass;
    t_no_resv_and_miss;
    t_remote_hit;
    t_remote_miss;
    t_local;
    t_sc_clears;
    t_expiry;
    t_relr_no_restart;
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule